// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block turns three digitized rotor-position sensor bits and a direction bit into six gate enables for a three-phase bridge. The bridge has one high-side and one low-side switch per phase. Each legal sensor code selects one phase to source current through its high-side switch and one phase to sink current through its low-side switch. Drive strength comes from chopping only the low-side switch with an externally generated PWM on-signal. The high-side switch of the source phase stays fully on for as long as its pair is selected.

The block also applies the bridge protections. Start/stop and the thermal-fault flag remove the whole pair. A lock-protection fault and a current-limit trip open only the low-side switches. A current-limit trip is held until the next PWM period begins. Whenever an enabled pair is withdrawn, all switches stay open for a parameterised dead-time before any pair is enabled again. This guards against shoot-through on direction reversals and on sensor steps.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_i` low, sensor codes map as follows, with `hall_i[2]` as sensor 1 and `hall_i[0]` as sensor 3, and output bit 0 as phase 1. Code 101 sources phase 2 and sinks phase 1. Code 100 sources 3 and sinks 1. Code 110 sources 3 and sinks 2. Code 010 sources 1 and sinks 2. Code 011 sources 1 and sinks 3. Code 001 sources 2 and sinks 3.
- R2: With `dir_i` high, the pair is the one R1 gives for the bitwise complement of `hall_i`. For example, 010 then sources phase 2 and sinks phase 1.
- R3: Sensor codes 000 and 111 open all six switches one cycle later.
- R4: While a pair is enabled, the source high-side enable is held steadily on. The sink low-side enable equals `pwm_on_i` delayed by one clock.
- R5: A high `ilim_trip_i` opens the low-side switches from the next cycle onward. They stay open until a rising edge of `pwm_on_i` arrives with no trip in the same cycle. A trip in the same cycle as a rising edge keeps them open.
- R6: A high `lock_flt_i` opens all low-side switches one cycle later and leaves the high-side enable unchanged.
- R7: With `run_i` low, all six switches are open one cycle later.
- R8: With `therm_flt_i` high, all six switches are open one cycle later, and they stay open until the flag clears.
- R9: Once an enabled pair is withdrawn, whether by a code change, a direction change, an illegal code, stop or thermal fault, the outputs stay all-off for exactly DEAD_CYC cycles before the requested pair appears.
- R10: At most one high-side and at most one low-side enable is on at a time, and never both switches of the same phase. A pair can never be replaced by another pair without an off cycle in between.
- R11: In reset, all outputs are off and the dead-time counter is zero. The first legal request after reset is enabled one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Digitized sensors; bit 2 is sensor 1, bit 0 is sensor 3 |
| dir_i | input | 1 | 0 selects the forward table, 1 the complemented-code table |
| run_i | input | 1 | 1 runs the motor, 0 stops it |
| pwm_on_i | input | 1 | PWM on-phase for the low-side switch |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| therm_flt_i | input | 1 | Thermal fault flag |
| lock_flt_i | input | 1 | Lock-protection fault flag |
| hs_en_o | output | 3 | High-side enables, bit n is phase n+1 |
| ls_en_o | output | 3 | Low-side enables, bit n is phase n+1 |

## Verification
Every gating input (stop, thermal, lock, current limit, PWM, illegal code) reaches the outputs at the first clock edge after it is applied. The bench therefore drives at a falling edge and checks at the next falling edge. A pair change is due DEAD_CYC edges after the edge that withdrew the old pair. The directed tests wait DEAD_CYC+1 falling edges, or count the all-off samples and compare the count with DEAD_CYC. In the random phase, a cycle model clocked on the same rising edge predicts both outputs, and the bench compares them at every falling edge.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

    localparam int NPH = 3;

    // One selected bridge pair: one-hot source phase and one-hot sink phase.
    typedef struct packed {
        logic [NPH-1:0] src;
        logic [NPH-1:0] snk;
    } pair_t;

    localparam pair_t PAIR_OFF = '0;

    // Forward-direction table; code bit 2 is sensor 1.
    function automatic pair_t fwd_pair(input logic [NPH-1:0] code);
        pair_t p;
        unique case (code)
            3'b101:  begin p.src = 3'b010; p.snk = 3'b001; end
            3'b100:  begin p.src = 3'b100; p.snk = 3'b001; end
            3'b110:  begin p.src = 3'b100; p.snk = 3'b010; end
            3'b010:  begin p.src = 3'b001; p.snk = 3'b010; end
            3'b011:  begin p.src = 3'b001; p.snk = 3'b100; end
            3'b001:  begin p.src = 3'b010; p.snk = 3'b100; end
            default: p = PAIR_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hcm_hall_decode.sv
module hcm_hall_decode
    import hcm_pkg::*;
(
    input  logic [NPH-1:0] hall_i,
    input  logic           dir_i,
    output pair_t          want_o,
    output logic           legal_o
);

    logic [NPH-1:0] code;

    always_comb begin
        // Reverse direction reuses the forward table on the complemented code.
        code    = dir_i ? ~hall_i : hall_i;
        want_o  = fwd_pair(code);
        legal_o = (code != '0) && (code != '1);
    end

endmodule

// File: rtl/hcm_pair_seq.sv
module hcm_pair_seq
    import hcm_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pair_t want_i,
    input  logic  allow_i,
    output pair_t cur_q_o,
    output pair_t cur_d_o
);

    localparam int CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        pair_t            cur;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!allow_i) begin
            // Withdraw; start the off window if a pair was live.
            st_d.cur = PAIR_OFF;
            if (st_q.cur != PAIR_OFF) begin
                st_d.cnt = RELOAD;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (st_q.cur != PAIR_OFF) begin
            if (want_i != st_q.cur) begin
                st_d.cur = PAIR_OFF;
                st_d.cnt = RELOAD;
            end
        end else if (st_q.cnt == '0) begin
            st_d.cur = want_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_q_o = st_q.cur;
    assign cur_d_o = st_d.cur;

endmodule

// File: rtl/hcm_lowside_gate.sv
module hcm_lowside_gate
    import hcm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] snk_next_i,
    input  logic           pwm_on_i,
    input  logic           ilim_trip_i,
    input  logic           lock_flt_i,
    output logic [NPH-1:0] ls_en_o
);

    typedef struct packed {
        logic           lim;
        logic           pwm_prev;
        logic [NPH-1:0] ls;
    } gate_t;

    gate_t g_q, g_d;
    logic  pwm_rise;
    logic  chop_ok;

    always_comb begin
        g_d      = g_q;
        pwm_rise = pwm_on_i && !g_q.pwm_prev;
        // A trip wins over a period start in the same cycle.
        if (ilim_trip_i) begin
            g_d.lim = 1'b1;
        end else if (pwm_rise) begin
            g_d.lim = 1'b0;
        end
        g_d.pwm_prev = pwm_on_i;
        chop_ok      = pwm_on_i && !g_d.lim && !lock_flt_i;
        g_d.ls       = snk_next_i & {NPH{chop_ok}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign ls_en_o = g_q.ls;

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hcm_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    input  logic       run_i,
    input  logic       pwm_on_i,
    input  logic       ilim_trip_i,
    input  logic       therm_flt_i,
    input  logic       lock_flt_i,
    output logic [2:0] hs_en_o,
    output logic [2:0] ls_en_o
);

    pair_t want;
    logic  legal;
    logic  allow;
    pair_t cur_q;
    pair_t cur_d;

    hcm_hall_decode u_dec (
        .hall_i  (hall_i),
        .dir_i   (dir_i),
        .want_o  (want),
        .legal_o (legal)
    );

    assign allow = legal && run_i && !therm_flt_i;

    hcm_pair_seq #(
        .DEAD_CYC (DEAD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want),
        .allow_i (allow),
        .cur_q_o (cur_q),
        .cur_d_o (cur_d)
    );

    hcm_lowside_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .snk_next_i  (cur_d.snk),
        .pwm_on_i    (pwm_on_i),
        .ilim_trip_i (ilim_trip_i),
        .lock_flt_i  (lock_flt_i),
        .ls_en_o     (ls_en_o)
    );

    assign hs_en_o = cur_q.src;

endmodule

// File: rtl/hcm_chk.sv
module hcm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       run_i,
    input logic       pwm_on_i,
    input logic       ilim_trip_i,
    input logic       therm_flt_i,
    input logic       lock_flt_i,
    input logic [2:0] hs_en_o,
    input logic [2:0] ls_en_o
);

    // R10
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_en_o) && $onehot0(ls_en_o));

    // R10
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o & ls_en_o) == 3'b000);

    // R10
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hs_en_o) != 3'b000 && hs_en_o != 3'b000) |-> hs_en_o == $past(hs_en_o));

    // R4
    sink_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en_o != 3'b000) |-> (hs_en_o != 3'b000));

    // R4
    pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_on_i |=> ls_en_o == 3'b000);

    // R3
    illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_i == 3'b000 || hall_i == 3'b111) |=> (hs_en_o | ls_en_o) == 3'b000);

    // R5
    ilim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_trip_i |=> ls_en_o == 3'b000);

    // R6
    lock_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flt_i |=> ls_en_o == 3'b000);

    // R7
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (hs_en_o | ls_en_o) == 3'b000);

    // R8
    therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_flt_i |=> (hs_en_o | ls_en_o) == 3'b000);

endmodule

bind hall_commutator hcm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hall_i      (hall_i),
    .run_i       (run_i),
    .pwm_on_i    (pwm_on_i),
    .ilim_trip_i (ilim_trip_i),
    .therm_flt_i (therm_flt_i),
    .lock_flt_i  (lock_flt_i),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o)
);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD       = 4;
    localparam int RAND_CYC   = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic       dir = 1'b0;
    logic       run = 1'b0;
    logic       pwm = 1'b0;
    logic       trip = 1'b0;
    logic       therm = 1'b0;
    logic       lock = 1'b0;
    logic [2:0] hs;
    logic [2:0] ls;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hall_commutator #(.DEAD_CYC(DEAD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hall_i      (hall),
        .dir_i       (dir),
        .run_i       (run),
        .pwm_on_i    (pwm),
        .ilim_trip_i (trip),
        .therm_flt_i (therm),
        .lock_flt_i  (lock),
        .hs_en_o     (hs),
        .ls_en_o     (ls)
    );

    // Requirement tables R1 and R2: returns {src, snk}
    function automatic logic [5:0] exp_pair(input logic [2:0] h, input logic d);
        logic [2:0] c;
        c = d ? ~h : h;
        case (c)
            3'b101:  return {3'b010, 3'b001};
            3'b100:  return {3'b100, 3'b001};
            3'b110:  return {3'b100, 3'b010};
            3'b010:  return {3'b001, 3'b010};
            3'b011:  return {3'b001, 3'b100};
            3'b001:  return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    // Cycle model built from R3..R11
    logic [2:0] m_src = 3'b0, m_snk = 3'b0, m_ls = 3'b0;
    int         m_cnt = 0;
    bit         m_lim = 1'b0, m_prev = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        logic [5:0] tgt;
        bit         ok;
        if (!rst_n) begin
            m_src = 3'b0; m_snk = 3'b0; m_ls = 3'b0;
            m_cnt = 0; m_lim = 1'b0; m_prev = 1'b0;
        end else begin
            tgt = exp_pair(hall, dir);
            ok  = run && !therm && (tgt != 6'b0);
            if (!ok) begin
                if (m_src != 3'b0) m_cnt = DEAD - 1;
                else if (m_cnt > 0) m_cnt = m_cnt - 1;
                m_src = 3'b0; m_snk = 3'b0;
            end else if (m_src != 3'b0) begin
                if (tgt != {m_src, m_snk}) begin
                    m_src = 3'b0; m_snk = 3'b0; m_cnt = DEAD - 1;
                end
            end else if (m_cnt == 0) begin
                {m_src, m_snk} = tgt;
            end else begin
                m_cnt = m_cnt - 1;
            end
            if (trip) m_lim = 1'b1;
            else if (pwm && !m_prev) m_lim = 1'b0;
            m_prev = pwm;
            m_ls = (pwm && !m_lim && !lock) ? m_snk : 3'b0;
        end
    end

    task automatic check(input string tag, input logic [2:0] act_hs, input logic [2:0] act_ls,
                         input logic [2:0] e_hs, input logic [2:0] e_ls);
        checks++;
        if (act_hs !== e_hs || act_ls !== e_ls) begin
            errors++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, act_hs, act_ls, e_hs, e_ls);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count all-off samples until a pair appears
    task automatic count_off(output int n);
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (hs != 3'b000) break;
            n++;
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4/R9 model", hs, ls, m_src, m_ls);
            checks++;
            if (((hs & ls) != 3'b000) || $countones(hs) > 1 || $countones(ls) > 1) begin
                errors++;
                $display("FAIL R10: hs=%b ls=%b expected disjoint one-hot", hs, ls);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] fwd_codes [6];
        logic [5:0] e;
        int n;
        fwd_codes = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        void'($urandom(32'd20240611));

        tick(3);
        check("R11 reset", hs, ls, 3'b000, 3'b000);
        rst_n = 1'b1;
        run = 1'b1; pwm = 1'b1; hall = 3'b101; dir = 1'b0;
        tick(1);
        check("R11 first pair one cycle after reset", hs, ls, 3'b010, 3'b001);

        // R1 forward table
        foreach (fwd_codes[i]) begin
            hall = fwd_codes[i];
            tick(DEAD + 1);
            e = exp_pair(fwd_codes[i], 1'b0);
            check("R1 forward", hs, ls, e[5:3], e[2:0]);
        end

        // R2 reverse table by complement
        dir = 1'b1;
        foreach (fwd_codes[i]) begin
            hall = fwd_codes[i];
            tick(DEAD + 1);
            e = exp_pair(~fwd_codes[i], 1'b0);
            check("R2 reverse", hs, ls, e[5:3], e[2:0]);
        end
        hall = 3'b010;
        tick(DEAD + 1);
        check("R2 example 010", hs, ls, 3'b010, 3'b001);

        // R9 dead time on a direction change
        dir = 1'b0;
        count_off(n);
        check_int("R9 dead cycles on direction flip", n, DEAD);
        check("R9 new pair after dead time", hs, ls, 3'b001, 3'b010);

        // R3 illegal codes
        hall = 3'b000;
        tick(1);
        check("R3 code 000", hs, ls, 3'b000, 3'b000);
        hall = 3'b111;
        tick(1);
        check("R3 code 111", hs, ls, 3'b000, 3'b000);
        hall = 3'b011;
        tick(DEAD + 1);
        check("R3 recovery", hs, ls, 3'b001, 3'b100);

        // R4 chopping only the sink
        pwm = 1'b0;
        tick(1);
        check("R4 pwm off", hs, ls, 3'b001, 3'b000);
        pwm = 1'b1;
        tick(1);
        check("R4 pwm on", hs, ls, 3'b001, 3'b100);

        // R5 current-limit latch
        trip = 1'b1;
        tick(1);
        check("R5 trip cuts sink", hs, ls, 3'b001, 3'b000);
        trip = 1'b0;
        tick(3);
        check("R5 held for rest of period", hs, ls, 3'b001, 3'b000);
        pwm = 1'b0;
        tick(1);
        pwm = 1'b1; trip = 1'b1;
        tick(1);
        check("R5 trip on rising edge keeps cut", hs, ls, 3'b001, 3'b000);
        trip = 1'b0; pwm = 1'b0;
        tick(1);
        pwm = 1'b1;
        tick(1);
        check("R5 cleared at next rising edge", hs, ls, 3'b001, 3'b100);

        // R6 lock fault
        lock = 1'b1;
        tick(1);
        check("R6 lock cuts low side", hs, ls, 3'b001, 3'b000);
        lock = 1'b0;
        tick(1);
        check("R6 lock release", hs, ls, 3'b001, 3'b100);

        // R7 stop and restart
        run = 1'b0;
        tick(1);
        check("R7 stop", hs, ls, 3'b000, 3'b000);
        run = 1'b1;
        count_off(n);
        check_int("R9 dead cycles after brief stop", n, DEAD - 1);

        // R8 thermal fault
        therm = 1'b1;
        tick(1);
        check("R8 thermal off", hs, ls, 3'b000, 3'b000);
        tick(DEAD + 3);
        check("R8 thermal held", hs, ls, 3'b000, 3'b000);
        therm = 1'b0;
        tick(1);
        check("R8 thermal clear", hs, ls, 3'b001, 3'b100);

        // Constrained random phase against the cycle model
        cmp_on = 1'b1;
        for (int c = 0; c < RAND_CYC; c++) begin
            @(negedge clk);
            #1;
            run   = ($urandom % 100) < 96;
            therm = ($urandom % 100) < 2;
            lock  = ($urandom % 100) < 4;
            trip  = ($urandom % 100) < 5;
            pwm   = (c % 9) < 6;
            if (($urandom % 100) < 2) dir = ~dir;
            if (($urandom % 100) < 3) hall = ($urandom % 2) ? 3'b000 : 3'b111;
            else if (($urandom % 100) < 12) hall = fwd_codes[$urandom % 6];
        end
        @(negedge clk);
        cmp_on = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule